// File: doc/BRIEF.md
# Pipelined BCD-to-Densely-Packed-Decimal Encoder

This block compresses decimal data held as three packed BCD digits (12 bits) into a single 10-bit densely packed decimal declet. Every digit is sorted into one of two classes by its top bit. A digit from 0 to 7 is "small" and keeps three payload bits. A digit of 8 or 9 is "large" and keeps only its low bit. The three class bits together choose one of eight bit arrangements for the declet. Each output bit is a flat two-level AND-OR expression of the input bits. A single register stage follows the logic, so the block accepts a new triple on every clock.

The block can hold several independent encoder lanes side by side. All lanes share one valid signal and one register stage. Lane `n` reads input bits `[12n+11:12n]` and writes declet bits `[10n+9:10n]`. Input nibbles with values 10 to 15 are outside the supported range, and the block produces no defined declet for them.

Top module: `dpd_encoder_pipe`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `out_valid` is 0 after that edge.
- R2: Out of reset, `out_valid` after each rising edge equals the `in_valid` sampled at that edge.
- R3: A triple sampled with `in_valid` high appears, encoded, on `out_declet` after that same edge. When `in_valid` is low, `out_declet` holds its previous value.
- R4: The low bit of each digit passes through unchanged. Within a lane, input bits 8, 4 and 0 (the low bits of the high, middle and low digits) appear at declet bits 7, 4 and 0.
- R5: When all three digits are small (input bits 11, 7 and 3 are all 0), the declet is built from the input in this order: bits 10..8, then 6..4, then 0, then 2..0. Declet bit 3 is 0 in this case.
- R6: Declet bit 3 is 1 exactly when at least one digit is large.
- R7: When exactly one digit is large, the declet follows the fixed arrangement for that case:
  - High digit large: {j,k,d,f,g,h,1,1,0,m}.
  - Middle digit large: {b,c,d,j,k,h,1,0,1,m}.
  - Low digit large: {b,c,d,f,g,h,1,0,0,m}.
  - Here the high digit is abcd, the middle digit is efgh and the low digit is ijkm, with a the MSB of each.
- R8: When two or three digits are large, the declet follows the fixed arrangement for that case:
  - High and middle large: {j,k,d,0,0,h,1,1,1,m}.
  - High and low large: {f,g,d,0,1,h,1,1,1,m}.
  - Middle and low large: {b,c,d,1,0,h,1,1,1,m}.
  - All three large: {0,0,d,1,1,h,1,1,1,m}.
- R9: These triples give these declets: 005 → 0000000101, 009 → 0000001001, 055 → 0001010101, 099 → 0001011111, 555 → 1011010101, 999 → 0011111111.
- R10: For triples 000 through 079, declet bits 6..0 equal input bits 6..0, and declet bits 9..7 are 0.
- R11: For all 1000 valid triples, decoding the declet gives back the original triple.
- R12: Lanes are independent. Each lane's declet depends only on its own input slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The input triples are valid this cycle |
| in_bcd | input | 12*LANES | Packed BCD triples, one per lane, high digit at the top of each slice |
| out_valid | output | 1 | Registered copy of in_valid |
| out_declet | output | 10*LANES | Registered declets, one per lane |

## Verification
The encoder is driven through every one of the 1000 valid triples, with the second lane receiving the mirror value at the same time.

- The exhaustive sweep covers all eight class combinations. Each combination is tagged with its requirement, so a wrong term in one case is named directly.
- The sweep also gives the round-trip decode check and the check of the range from 0 to 79.
- Directed triples are compared against the six fixed reference declets.
- Random stretches mix valid and idle cycles. These separate a correct load enable from a register that loads on every cycle.
- A reset in the middle of traffic shows that valid is cleared.

// File: rtl/dpd_enc_pkg.sv
package dpd_enc_pkg;

    localparam int DIGIT_W  = 4;
    localparam int DIGITS   = 3;
    localparam int BCD_W    = DIGIT_W * DIGITS;
    localparam int DECLET_W = 10;

    // Three BCD digits, most significant first.
    typedef struct packed {
        logic [DIGIT_W-1:0] hi;
        logic [DIGIT_W-1:0] mid;
        logic [DIGIT_W-1:0] lo;
    } bcd_triple_t;

    // Declet fields, from the top bit down.
    typedef struct packed {
        logic [2:0] head;    // bits 9..7
        logic [2:0] body;    // bits 6..4
        logic       marker;  // bit 3: set when any digit is large
        logic [2:0] tail;    // bits 2..0
    } declet_t;

    // A digit counts as large (8 or 9) when its top bit is set.
    function automatic logic is_large(input logic [DIGIT_W-1:0] dg);
        return dg[DIGIT_W-1];
    endfunction

endpackage

// File: rtl/dpd_sop_core.sv
module dpd_sop_core
    import dpd_enc_pkg::*;
(
    input  bcd_triple_t triple,
    output declet_t     code
);
    // Class bits, one per digit.
    logic big_h, big_m, big_l;
    // Payload bits of each digit.
    logic h2, h1, h0, m2, m1, m0, l2, l1, l0;

    assign big_h = is_large(triple.hi);
    assign big_m = is_large(triple.mid);
    assign big_l = is_large(triple.lo);
    assign {h2, h1, h0} = triple.hi[2:0];
    assign {m2, m1, m0} = triple.mid[2:0];
    assign {l2, l1, l0} = triple.lo[2:0];

    // Each bit is a flat sum of products. No product term is shared or
    // chained between bits, so each bit stays at AND then OR depth.
    assign code.head[2] = (h2 & ~big_h)
                        | (l2 &  big_h & ~big_l)
                        | (m2 &  big_h & ~big_m &  big_l);
    assign code.head[1] = (h1 & ~big_h)
                        | (l1 &  big_h & ~big_l)
                        | (m1 &  big_h & ~big_m &  big_l);
    assign code.head[0] = h0;

    assign code.body[2] = (m2 & ~big_m & ~big_l)
                        | (m2 & ~big_h & ~big_m)
                        | (l2 & ~big_h &  big_m & ~big_l)
                        | (big_m & big_l);
    assign code.body[1] = (m1 & ~big_h & ~big_m)
                        | (m1 & ~big_m & ~big_l)
                        | (l1 & ~big_h &  big_m & ~big_l)
                        | (big_h & big_l);
    assign code.body[0] = m0;

    assign code.marker  = big_h | big_m | big_l;

    assign code.tail[2] = (l2 & ~big_h & ~big_m & ~big_l)
                        | (big_m & big_l)
                        | big_h;
    assign code.tail[1] = (l1 & ~big_h & ~big_m & ~big_l)
                        | (big_h & big_l)
                        | big_m;
    assign code.tail[0] = l0;

endmodule

// File: rtl/dpd_pipe_reg.sv
module dpd_pipe_reg #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else if (load)
            dout <= din;
    end
endmodule

// File: rtl/dpd_encoder_pipe.sv
module dpd_encoder_pipe
    import dpd_enc_pkg::*;
#(
    parameter int LANES = 1,
    localparam int IN_W  = BCD_W * LANES,
    localparam int OUT_W = DECLET_W * LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_bcd,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_declet
);
    logic [OUT_W-1:0] comb_declet;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        bcd_triple_t lane_in;
        declet_t     lane_out;

        assign lane_in = bcd_triple_t'(in_bcd[ln*BCD_W +: BCD_W]);

        dpd_sop_core u_core (
            .triple (lane_in),
            .code   (lane_out)
        );

        assign comb_declet[ln*DECLET_W +: DECLET_W] = lane_out;
    end

    dpd_pipe_reg #(.WIDTH(OUT_W)) u_data_reg (
        .clk  (clk),
        .rst  (rst),
        .load (in_valid),
        .din  (comb_declet),
        .dout (out_declet)
    );

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

endmodule

// File: rtl/dpd_encoder_pipe_chk.sv
module dpd_encoder_pipe_chk
    import dpd_enc_pkg::*;
#(
    parameter int LANES = 1,
    localparam int IN_W  = BCD_W * LANES,
    localparam int OUT_W = DECLET_W * LANES
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_bcd,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_declet
);
    // R1
    reset_clears_valid_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R3
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_declet));

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane_chk
        // R4
        lsb_pass_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=>
                (out_declet[ln*DECLET_W + 7] == $past(in_bcd[ln*BCD_W + 8])) &&
                (out_declet[ln*DECLET_W + 4] == $past(in_bcd[ln*BCD_W + 4])) &&
                (out_declet[ln*DECLET_W + 0] == $past(in_bcd[ln*BCD_W + 0])));

        // R6
        marker_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=>
                (out_declet[ln*DECLET_W + 3] ==
                 $past(in_bcd[ln*BCD_W + 11] | in_bcd[ln*BCD_W + 7] |
                       in_bcd[ln*BCD_W + 3])));
    end
endmodule

bind dpd_encoder_pipe dpd_encoder_pipe_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/dpd_encoder_pipe_test.sv
module dpd_encoder_pipe_test;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [12*NL-1:0] in_bcd = '0;
    logic            out_valid;
    logic [10*NL-1:0] out_declet;

    int checks = 0;
    int fails  = 0;
    logic [9:0] last0, last1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpd_encoder_pipe #(.LANES(NL)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bcd(in_bcd),
        .out_valid(out_valid), .out_declet(out_declet)
    );

    // Reference encoder written from the case table.
    function automatic logic [9:0] ref_enc(input logic [11:0] t);
        logic a, b, c, d, e, f, g, h, i, j, k, m;
        {a, b, c, d, e, f, g, h, i, j, k, m} = t;
        case ({a, e, i})
            3'b000: return {b, c, d, f, g, h, 1'b0, j, k, m};
            3'b001: return {b, c, d, f, g, h, 1'b1, 2'b00, m};
            3'b010: return {b, c, d, j, k, h, 1'b1, 2'b01, m};
            3'b011: return {b, c, d, 2'b10, h, 1'b1, 2'b11, m};
            3'b100: return {j, k, d, f, g, h, 1'b1, 2'b10, m};
            3'b101: return {f, g, d, 2'b01, h, 1'b1, 2'b11, m};
            3'b110: return {j, k, d, 2'b00, h, 1'b1, 2'b11, m};
            default: return {2'b00, d, 2'b11, h, 1'b1, 2'b11, m};
        endcase
    endfunction

    // Reference decoder from the declet back to three BCD digits.
    function automatic logic [11:0] ref_dec(input logic [9:0] x);
        logic [2:0] hd, bd, tl;
        logic mk;
        {hd, bd, mk, tl} = x;
        if (!mk) return {1'b0, hd, 1'b0, bd, 1'b0, tl};
        case (tl[2:1])
            2'b00: return {1'b0, hd, 1'b0, bd, 3'b100, tl[0]};
            2'b01: return {1'b0, hd, 3'b100, bd[0], 1'b0, bd[2:1], tl[0]};
            2'b10: return {3'b100, hd[0], 1'b0, bd, 1'b0, hd[2:1], tl[0]};
            default:
                case (bd[2:1])
                    2'b00: return {3'b100, hd[0], 3'b100, bd[0], 1'b0, hd[2:1], tl[0]};
                    2'b01: return {3'b100, hd[0], 1'b0, hd[2:1], bd[0], 3'b100, tl[0]};
                    2'b10: return {1'b0, hd, 3'b100, bd[0], 3'b100, tl[0]};
                    default: return {3'b100, hd[0], 3'b100, bd[0], 3'b100, tl[0]};
                endcase
        endcase
    endfunction

    function automatic logic [11:0] to_bcd(input int n);
        return {4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
    endfunction

    function automatic string case_req(input logic [11:0] t);
        int nl = int'(t[11]) + int'(t[7]) + int'(t[3]);
        if (nl == 0) return "R5";
        if (nl == 1) return "R7";
        return "R8";
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Drive at a falling edge; the result is sampled at the next falling edge.
    task automatic step(input logic v, input logic [11:0] t0, input logic [11:0] t1);
        in_valid = v;
        in_bcd   = {t1, t0};
        @(negedge clk);
    endtask

    task automatic check_lanes(input logic [11:0] t0, input logic [11:0] t1);
        check(case_req(t0), 32'(out_declet[9:0]), 32'(ref_enc(t0)));
        check("R12", 32'(out_declet[19:10]), 32'(ref_enc(t1)));
        check("R4", 32'({out_declet[7], out_declet[4], out_declet[0]}),
              32'({t0[8], t0[4], t0[0]}));
        check("R6", 32'(out_declet[3]), 32'(t0[11] | t0[7] | t0[3]));
        check("R11", 32'(ref_dec(out_declet[9:0])), 32'(t0));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] dir_in [6];
        logic [9:0]  dir_out [6];
        void'($urandom(32'd4242));
        dir_in  = '{12'h005, 12'h009, 12'h055, 12'h099, 12'h555, 12'h999};
        dir_out = '{10'b0000000101, 10'b0000001001, 10'b0001010101,
                    10'b0001011111, 10'b1011010101, 10'b0011111111};

        @(negedge clk);
        @(negedge clk);
        check("R1", 32'(out_valid), 32'd0);
        rst = 1'b0;

        // Exhaustive sweep; lane 1 gets the mirror value.
        for (int n = 0; n < 1000; n++) begin
            logic [11:0] t0, t1;
            t0 = to_bcd(n);
            t1 = to_bcd(999 - n);
            step(1'b1, t0, t1);
            check("R2", 32'(out_valid), 32'd1);
            check_lanes(t0, t1);
            if (n < 80) begin
                check("R10", 32'(out_declet[9:0]), 32'({3'b000, t0[6:0]}));
            end
        end

        // Directed reference values.
        for (int q = 0; q < 6; q++) begin
            step(1'b1, dir_in[q], 12'h000);
            check("R9", 32'(out_declet[9:0]), 32'(dir_out[q]));
        end

        // Idle input is ignored: declet holds, valid drops.
        last0 = out_declet[9:0];
        last1 = out_declet[19:10];
        step(1'b0, 12'h987, 12'h123);
        check("R2", 32'(out_valid), 32'd0);
        check("R3", 32'(out_declet), 32'({last1, last0}));

        // Random mix of valid and idle cycles.
        for (int r = 0; r < 400; r++) begin
            logic v;
            logic [11:0] t0, t1;
            v  = 1'($urandom_range(0, 1));
            t0 = to_bcd(int'($urandom_range(0, 999)));
            t1 = to_bcd(int'($urandom_range(0, 999)));
            last0 = out_declet[9:0];
            last1 = out_declet[19:10];
            step(v, t0, t1);
            check("R2", 32'(out_valid), 32'(v));
            if (v) check_lanes(t0, t1);
            else   check("R3", 32'(out_declet), 32'({last1, last0}));
        end

        // Reset in the middle of traffic.
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R1", 32'(out_valid), 32'd0);
        rst = 1'b0;
        step(1'b1, 12'h980, 12'h089);
        check("R2", 32'(out_valid), 32'd1);
        check_lanes(12'h980, 12'h089);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule